// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter with a period register. A fixed-rate `tick` input drives the counter through a prescaler. The prescaler divides by 1, 4 or 16, chosen by a 2-bit code. On every prescaled tick the counter is compared against the period. When the two are equal, the counter restarts from zero and a one-clock match pulse is raised. That pulse leaves the block unchanged on `matchPulse`, so a serial shifter next to the timer can use it as its shift clock.

A 4-bit postscaler counts match events. After every k+1 of them it sets a sticky interrupt flag, where k is the postscale code. Software clears the flag with `intClr`. A small register port reaches the count, the period and a control byte. Writes are latched at the clock edge that ends the write cycle. Reads return the addressed value combinationally.

Top module: `period_match_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control byte reads 00h, and `matchPulse` and `intFlag` are low.
- R2: `addr` selects the register: 0 is the count, 1 is the period, 2 is the control byte and 3 always reads 0. A write with `wrEn` high lands on the next rising clock edge. Bit 7 of the control byte always reads 0.
- R3: Control bits 1:0 select the prescale. 00 advances the count on every enabled tick, 01 on every 4th, and both 10 and 11 on every 16th.
- R4: On a prescaled tick the count increments, except when it equals the period. In that case it returns to 00h and `matchPulse` is high for the following clock cycle. A full cycle is therefore period+1 prescaled ticks.
- R5: While control bit 2 (enable) is 0, ticks have no effect: the count and the prescaler hold and `matchPulse` stays low.
- R6: Control bits 6:3 hold a postscale value k. `intFlag` goes high together with every (k+1)-th `matchPulse`, so 0000 gives 1:1 and 1111 gives 1:16.
- R7: `intFlag` stays high until a cycle with `intClr` high. If a postscaler terminal count falls in that same cycle, the flag stays set.
- R8: A count write loads the new value and clears both the prescaler and the postscaler. A tick in the same cycle is ignored, so the written value is kept.
- R9: A control write clears both scaler counters, and a tick in that cycle is ignored. The count keeps its value.
- R10: `matchPulse` is raised on every match, whatever the postscale setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Fixed-rate count enable from the clock divider |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| intClr | input | 1 | Clears the interrupt flag |
| matchPulse | output | 1 | One-clock pulse on each period match |
| intFlag | output | 1 | Sticky postscaled interrupt flag |

## Verification
A per-cycle reference model runs the counter under several tick patterns: `tick` held high, `tick` random, and `tick` low. Holding `tick` high isolates the prescale ratios. Random ticks show whether the prescaler counts ticks or clocks. A low `tick`, or a clear enable bit, shows whether anything advances without permission. Writes to the count and to the control byte are placed on cycles where `tick` is high, which separates the clear and ignore rules of R8 and R9. A period of 0 with 1:1 postscaling raises a terminal count on every cycle, and holding `intClr` high through it exercises the set-over-clear priority.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  localparam int PRE_W = 4;                       // covers the largest divide (16)
  localparam logic [PRE_W-1:0] PRE_TERM_ONE  = 4'd0;
  localparam logic [PRE_W-1:0] PRE_TERM_FOUR = 4'd3;
  localparam logic [PRE_W-1:0] PRE_TERM_MAX  = 4'd15;

  localparam int EN_BIT = 2;

  // Strobes from the control side into the datapath
  typedef struct packed {
    logic loadCount;     // count write this cycle
    logic clearScalers;  // count or control write this cycle
    logic advance;       // qualified tick: enabled and no blocking write
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POST_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   countVal,
  output tmrStrobe_t          strobe,
  output logic [DATA_W-1:0]   periodVal,
  output logic [1:0]          preSel,
  output logic [POST_W-1:0]   postSel,
  output logic [DATA_W-1:0]   rdData
);
  localparam int CTRL_W   = POST_W + 3;
  localparam int POST_LSB = 3;

  logic [CTRL_W-1:0] ctrlQ;
  logic [DATA_W-1:0] periodQ;
  logic wrCount, wrPeriod, wrCtrl;

  assign wrCount  = wrEn && (addr == ADDR_COUNT);
  assign wrPeriod = wrEn && (addr == ADDR_PERIOD);
  assign wrCtrl   = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '1;
      ctrlQ   <= '0;
    end else begin
      if (wrPeriod) periodQ <= wrData;
      if (wrCtrl)   ctrlQ   <= wrData[CTRL_W-1:0];
    end
  end

  always_comb begin
    strobe.loadCount    = wrCount;
    strobe.clearScalers = wrCount | wrCtrl;
    strobe.advance      = tick & ctrlQ[EN_BIT] & ~(wrCount | wrCtrl);
  end

  assign periodVal = periodQ;
  assign preSel    = ctrlQ[1:0];
  assign postSel   = ctrlQ[CTRL_W-1:POST_LSB];

  always_comb begin
    unique case (addr)
      ADDR_COUNT:  rdData = countVal;
      ADDR_PERIOD: rdData = periodQ;
      ADDR_CTRL:   rdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POST_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmrStrobe_t         strobe,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DATA_W-1:0]  periodVal,
  input  logic [1:0]         preSel,
  input  logic [POST_W-1:0]  postSel,
  input  logic               intClr,
  output logic [DATA_W-1:0]  countVal,
  output logic               matchPulse,
  output logic               intFlag
);
  logic [PRE_W-1:0]  preCnt, preTerm;
  logic [POST_W-1:0] postCnt;
  logic [DATA_W-1:0] countQ;
  logic preHit, isMatch, postHit, matchQ, intQ;

  always_comb begin
    unique case (preSel)
      2'b00:   preTerm = PRE_TERM_ONE;
      2'b01:   preTerm = PRE_TERM_FOUR;
      default: preTerm = PRE_TERM_MAX;
    endcase
  end

  assign preHit  = strobe.advance && (preCnt == preTerm);
  assign isMatch = preHit && (countQ == periodVal);
  assign postHit = isMatch && (postCnt == postSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      postCnt <= '0;
      countQ  <= '0;
      matchQ  <= 1'b0;
      intQ    <= 1'b0;
    end else begin
      matchQ <= isMatch;
      intQ   <= postHit | (intQ & ~intClr);
      if (strobe.loadCount)  countQ <= wrData;
      else if (preHit)       countQ <= isMatch ? '0 : countQ + 1'b1;
      if (strobe.clearScalers) begin
        preCnt  <= '0;
        postCnt <= '0;
      end else begin
        if (strobe.advance) preCnt  <= preHit ? '0 : preCnt + 1'b1;
        if (isMatch)        postCnt <= postHit ? '0 : postCnt + 1'b1;
      end
    end
  end

  assign countVal   = countQ;
  assign matchPulse = matchQ;
  assign intFlag    = intQ;
endmodule

// File: rtl/period_match_timer.sv
module period_match_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              intClr,
  output logic              matchPulse,
  output logic              intFlag
);
  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] countVal, periodVal;
  logic [1:0]        preSel;
  logic [POST_W-1:0] postSel;

  tmr_ctrl #(.DATA_W(DATA_W), .POST_W(POST_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .countVal(countVal), .strobe(strobe),
    .periodVal(periodVal), .preSel(preSel), .postSel(postSel), .rdData(rdData)
  );

  tmr_datapath #(.DATA_W(DATA_W), .POST_W(POST_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .periodVal(periodVal), .preSel(preSel), .postSel(postSel), .intClr(intClr),
    .countVal(countVal), .matchPulse(matchPulse), .intFlag(intFlag)
  );
endmodule

// File: rtl/period_match_timer_chk.sv
module period_match_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdData,
  input logic              intClr,
  input logic              matchPulse,
  input logic              intFlag
);
  p_int_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    intFlag && !intClr |=> intFlag);
  p_int_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    intClr && !tick |=> !intFlag);
  p_int_from_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intFlag) |-> matchPulse);
  p_idle_no_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !matchPulse);
  p_count_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0) |=> !matchPulse);
  p_ctrl_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2) |=> !matchPulse);
  p_ctrl_msb_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd2) |-> !rdData[DATA_W-1]);
  p_spare_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 2'd3) |-> (rdData == '0));
endmodule

bind period_match_timer period_match_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
  .rdData(rdData), .intClr(intClr), .matchPulse(matchPulse), .intFlag(intFlag)
);

// File: tb/tb_period_match_timer.sv
`timescale 1ns/1ps
module tb_period_match_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, wrEn = 1'b0, intClr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic matchPulse, intFlag;

  always #4 clk = ~clk;   // 125 MHz

  period_match_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .intClr(intClr),
    .matchPulse(matchPulse), .intFlag(intFlag)
  );

  typedef struct {
    logic [7:0] count, period, ctrl;
    logic match, intf;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0, nFails = 0;
  string curReq = "R1";
  bit finished = 0;

  // Reference model built from the requirements, sampled at each rising edge
  logic [7:0] mCount, mPeriod, mCtrl;
  logic mMatch, mInt;
  int mPre, mPost;
  always @(posedge clk) begin
    expItem_t it;
    bit setFlag;
    int div;
    logic [7:0] newPeriod;
    setFlag = 0;
    if (!rstN) begin
      mCount = 8'h00; mPeriod = 8'hFF; mCtrl = 8'h00;
      mMatch = 0; mInt = 0; mPre = 0; mPost = 0;
    end else begin
      mMatch = 0;
      newPeriod = (wrEn && addr == 2'd1) ? wrData : mPeriod;
      if (wrEn && addr == 2'd0) begin          // R8
        mCount = wrData; mPre = 0; mPost = 0;
      end else if (wrEn && addr == 2'd2) begin // R9
        mCtrl = wrData & 8'h7F; mPre = 0; mPost = 0;
      end else if (mCtrl[2] && tick) begin     // R5 gate
        div = (mCtrl[1:0] == 2'b00) ? 1 : (mCtrl[1:0] == 2'b01) ? 4 : 16; // R3
        mPre++;
        if (mPre == div) begin
          mPre = 0;
          if (mCount == mPeriod) begin         // R4
            mCount = 8'h00; mMatch = 1;
            mPost++;
            if (mPost == int'(mCtrl[6:3]) + 1) begin mPost = 0; setFlag = 1; end // R6
          end else mCount = mCount + 8'd1;
        end
      end
      mPeriod = newPeriod;
      mInt = setFlag | (mInt & ~intClr);      // R7
    end
    it.count = mCount; it.period = mPeriod; it.ctrl = mCtrl;
    it.match = mMatch; it.intf = mInt;
    expQ.push_back(it);
  end

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Monitor: pops the scoreboard away from the edge
  always @(posedge clk) begin
    #2;
    if (!finished && expQ.size() > 0) begin
      expItem_t e;
      int expRd;
      e = expQ.pop_front();
      check(curReq, "matchPulse", matchPulse, e.match);  // R10 when postscale set
      check(curReq, "intFlag", intFlag, e.intf);
      case (addr)
        2'd0: expRd = e.count;
        2'd1: expRd = e.period;
        2'd2: expRd = e.ctrl;
        default: expRd = 0;
      endcase
      check(curReq, "rdData", rdData, expRd);
    end
  end

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0; addr = $urandom % 4;
  endtask

  // mode 0: tick high, 1: random tick, 2: tick low
  task automatic run(int n, int mode, int clrPct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick   = (mode == 0) ? 1'b1 : (mode == 1) ? 1'($urandom % 2) : 1'b0;
      intClr = (($urandom % 100) < clrPct);
      addr   = $urandom % 4;
    end
  endtask

  task automatic readAt(logic [1:0] a);
    @(negedge clk); addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    rstN = 1;
    readAt(0); readAt(1); readAt(2); readAt(3);

    curReq = "R2";
    wrReg(2'd1, 8'h05); readAt(1);
    wrReg(2'd2, 8'hF8); readAt(2);   // enable off, bit7 must read 0
    wrReg(2'd0, 8'h3C); readAt(0); readAt(3);
    wrReg(2'd0, 8'h00); wrReg(2'd2, 8'h00);

    curReq = "R4";
    wrReg(2'd1, 8'h03); wrReg(2'd2, 8'h04); run(40, 0, 0);
    wrReg(2'd1, 8'h00); run(20, 0, 0);
    wrReg(2'd1, 8'h07); run(60, 1, 0);

    curReq = "R3";
    wrReg(2'd1, 8'h02); wrReg(2'd2, 8'h05); run(80, 0, 0);
    wrReg(2'd2, 8'h06); run(200, 0, 0);
    wrReg(2'd2, 8'h07); run(200, 0, 0);
    wrReg(2'd2, 8'h05); run(150, 1, 0);

    curReq = "R6";
    wrReg(2'd1, 8'h02); wrReg(2'd2, 8'h14); run(120, 0, 20);
    wrReg(2'd2, 8'h7C); run(300, 0, 5);
    wrReg(2'd2, 8'h0C); run(100, 1, 10);

    curReq = "R10";
    wrReg(2'd1, 8'h01); wrReg(2'd2, 8'h3C); run(60, 0, 0);

    curReq = "R7";
    wrReg(2'd1, 8'h00); wrReg(2'd2, 8'h04);
    run(10, 0, 100);                 // set wins over a held clear
    run(5, 2, 100);                  // no ticks: clear takes effect
    run(5, 2, 0);

    curReq = "R5";
    wrReg(2'd1, 8'h09); wrReg(2'd2, 8'h04); run(5, 0, 0);
    wrReg(2'd2, 8'h00); run(40, 0, 0);
    wrReg(2'd2, 8'h04); run(20, 0, 0);

    curReq = "R8";
    wrReg(2'd1, 8'h10); wrReg(2'd2, 8'h05); run(7, 0, 0);
    wrReg(2'd0, 8'h0E); run(30, 0, 0);
    wrReg(2'd0, 8'h10); run(10, 0, 0);
    wrReg(2'd0, 8'hFE); run(80, 0, 0);   // count above period wraps through FFh

    curReq = "R9";
    wrReg(2'd1, 8'h20); wrReg(2'd2, 8'h0C); run(45, 0, 0);
    wrReg(2'd2, 8'h0C); readAt(0); run(50, 0, 0);
    wrReg(2'd2, 8'h15); run(90, 1, 0);

    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog %s actual=hung expected=done", curReq);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule